// File: doc/BRIEF.md
# Line CRC Error Checker

This block watches the luma and chroma word streams of an HD or 3G serial digital video link, once the link has been deserialised and its timing codes located. For each stream it runs an 18-bit CRC over every line. The CRC starts at the first active-video word and ends at the second line-number word. It then takes the two CRC words that the transmitter embedded after the line number and compares them with its own result. A mismatch sets a sticky error flag for that stream. A malformed or missing embedded CRC word also sets the flag. In 3G operation, data stream 1 is wired to the Y input and data stream 2 to the C input.

Each word carries a tag that the upstream timing logic supplies. The tag marks the first covered word, the last covered word, the low and high CRC words, and the end of the line. Comparison happens only on the end-of-line word. The mode input turns checking off in SD. A regeneration input tells the checker that the CRC words are being rewritten downstream, for example after 8-bit timing codes are remapped to 10-bit values; while it is high, no result is recorded. Software clears each flag through its own bit of a clear input.

Top module: `line_crc_chk`

## Requirements
- R1: The line CRC uses the generator x^18 + x^5 + x^4 + 1 (feedback mask 0x00031). It is preset to zero on the word tagged FIRST (tag 1) and absorbs 10 bits per word, bit 0 first, shifting MSB-out. It covers every valid word from FIRST through the word tagged LAST (tag 2) inclusive. A line whose embedded CRC matches leaves the flag low.
- R2: The word tagged CRC_LO (tag 3) carries CRC bits 8:0 in its bits 8:0. The word tagged CRC_HI (tag 4) carries CRC bits 17:9. In each of them, bit 9 must be the inverse of bit 8. On the word tagged END (tag 5), a value mismatch or a bit 9 that breaks this rule sets `y_err_o` for the Y stream.
- R3: The C stream is checked in the same way but independently of Y, and only sets `c_err_o`.
- R4: If a line reaches END without having received both CRC words since FIRST, that stream's flag is set as for a mismatch.
- R5: Errors are recorded only when `mode_i` is 1 (HD) or 2 (3G). Mode 0 (SD) and mode 3 never set a flag.
- R6: While `crc_regen_i` is high, no error is recorded on either stream.
- R7: Flags are sticky. Bit 0 of `clr_i` clears the Y flag and bit 1 clears the C flag, one clock after the pulse. If a clear and a new error fall on the same edge, the flag stays set.
- R8: After reset both flags are low.
- R9: Words with `valid_i` low are ignored, whatever their data and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 SD, 1 HD, 2 3G, 3 reserved |
| crc_regen_i | input | 1 | CRC words are regenerated downstream; suppresses errors |
| valid_i | input | 1 | Word strobe for both streams |
| tag_i | input | 3 | Word tag: 0 none, 1 FIRST, 2 LAST, 3 CRC_LO, 4 CRC_HI, 5 END |
| y_data_i | input | 10 | Luma / stream 1 word |
| c_data_i | input | 10 | Chroma / stream 2 word |
| clr_i | input | 2 | Flag clear: bit 0 Y, bit 1 C |
| y_err_o | output | 1 | Sticky Y CRC error flag |
| c_err_o | output | 1 | Sticky C CRC error flag |

## Verification
The clear of a flag and a fresh error on the same stream can land on the same clock edge. The bench provokes this by pulsing both clear bits during the END word of a line whose Y CRC is corrupted and whose C CRC is correct. The expected result is that Y stays set, because the new error wins, and that C drops, because the clear is applied. Each END word is also driven with random tags and data on idle cycles around the covered words, so a wrong word absorbed into the CRC or a stray tag would show up as a false flag.

// File: rtl/lcrc_pkg.sv
package lcrc_pkg;
  typedef enum logic [2:0] {
    TAG_NONE   = 3'd0,
    TAG_FIRST  = 3'd1,
    TAG_LAST   = 3'd2,
    TAG_CRC_LO = 3'd3,
    TAG_CRC_HI = 3'd4,
    TAG_END    = 3'd5
  } tag_e;

  typedef enum logic [1:0] {
    MODE_SD   = 2'd0,
    MODE_HD   = 2'd1,
    MODE_3G   = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;
endpackage

// File: rtl/lcrc_engine.sv
module lcrc_engine
  import lcrc_pkg::*;
#(
  parameter int               DATA_W = 10,
  parameter int               CRC_W  = 18,
  parameter logic [CRC_W-1:0] POLY   = 18'h00031
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  tag_e              tag_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic             cover_q;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int b = 0; b < DATA_W; b++) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q   <= '0;
      cover_q <= 1'b0;
    end else if (valid_i) begin
      if (tag_i == TAG_FIRST) begin
        crc_q   <= crc_step('0, data_i);
        cover_q <= 1'b1;
      end else if (cover_q) begin
        crc_q <= crc_step(crc_q, data_i);
        if (tag_i == TAG_LAST) cover_q <= 1'b0;
      end
    end
  end

  assign crc_o = crc_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(crc_q)) else $error("crc changed on idle word"); // R9
endmodule

// File: rtl/lcrc_rx.sv
module lcrc_rx
  import lcrc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CRC_W  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  tag_e              tag_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  rx_crc_o,
  output logic              got_all_o,
  output logic              fmt_bad_o,
  output logic              in_line_o
);
  localparam int HALF = CRC_W / 2;

  logic [CRC_W-1:0] rx_q;
  logic             got_lo_q, got_hi_q, fmt_bad_q, in_line_q;
  logic             inv_bad;

  // word bit HALF must be the inverse of bit HALF-1
  assign inv_bad = (data_i[HALF] == data_i[HALF-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      got_lo_q  <= 1'b0;
      got_hi_q  <= 1'b0;
      fmt_bad_q <= 1'b0;
      in_line_q <= 1'b0;
    end else if (valid_i) begin
      unique case (tag_i)
        TAG_FIRST: begin
          in_line_q <= 1'b1;
          got_lo_q  <= 1'b0;
          got_hi_q  <= 1'b0;
          fmt_bad_q <= 1'b0;
        end
        TAG_CRC_LO: if (in_line_q) begin
          rx_q[HALF-1:0] <= data_i[HALF-1:0];
          got_lo_q       <= 1'b1;
          if (inv_bad) fmt_bad_q <= 1'b1;
        end
        TAG_CRC_HI: if (in_line_q) begin
          rx_q[CRC_W-1:HALF] <= data_i[HALF-1:0];
          got_hi_q           <= 1'b1;
          if (inv_bad) fmt_bad_q <= 1'b1;
        end
        TAG_END:  in_line_q <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign rx_crc_o  = rx_q;
  assign got_all_o = got_lo_q & got_hi_q;
  assign fmt_bad_o = fmt_bad_q;
  assign in_line_o = in_line_q;

  AST_LINE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && tag_i == TAG_FIRST) |=> (!got_all_o && in_line_o))
    else $error("capture not restarted"); // R4
endmodule

// File: rtl/lcrc_flag.sv
module lcrc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o) else $error("error lost"); // R7
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o) else $error("flag dropped"); // R7
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o) else $error("clear ignored"); // R7
endmodule

// File: rtl/lcrc_lane.sv
module lcrc_lane
  import lcrc_pkg::*;
#(
  parameter int               DATA_W = 10,
  parameter int               CRC_W  = 18,
  parameter logic [CRC_W-1:0] POLY   = 18'h00031
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  tag_e              tag_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              check_en_i,
  output logic              err_o
);
  logic [CRC_W-1:0] calc_crc, rx_crc;
  logic             got_all, fmt_bad, in_line, end_w;

  lcrc_engine #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_engine (
    .clk_i, .rst_ni, .valid_i, .tag_i, .data_i, .crc_o(calc_crc)
  );

  lcrc_rx #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_rx (
    .clk_i, .rst_ni, .valid_i, .tag_i, .data_i,
    .rx_crc_o(rx_crc), .got_all_o(got_all), .fmt_bad_o(fmt_bad), .in_line_o(in_line)
  );

  assign end_w = valid_i && (tag_i == TAG_END);
  assign err_o = end_w && in_line && check_en_i &&
                 (!got_all || fmt_bad || (rx_crc != calc_crc));
endmodule

// File: rtl/line_crc_chk.sv
module line_crc_chk
  import lcrc_pkg::*;
#(
  parameter int               DATA_W = 10,
  parameter int               CRC_W  = 18,
  parameter logic [CRC_W-1:0] POLY   = 18'h00031
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              crc_regen_i,
  input  logic              valid_i,
  input  logic [2:0]        tag_i,
  input  logic [DATA_W-1:0] y_data_i,
  input  logic [DATA_W-1:0] c_data_i,
  input  logic [1:0]        clr_i,
  output logic              y_err_o,
  output logic              c_err_o
);
  localparam int N_LANES = 2;

  logic [N_LANES-1:0][DATA_W-1:0] lane_data;
  logic [N_LANES-1:0]             lane_err, lane_flag;
  logic                           check_en;
  mode_e                          mode;
  tag_e                           tag;

  assign mode      = mode_e'(mode_i);
  assign tag       = tag_e'(tag_i);
  assign lane_data = {c_data_i, y_data_i};
  assign check_en  = ((mode == MODE_HD) || (mode == MODE_3G)) && !crc_regen_i;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    lcrc_lane #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_lane (
      .clk_i, .rst_ni, .valid_i, .tag_i(tag), .data_i(lane_data[g]),
      .check_en_i(check_en), .err_o(lane_err[g])
    );
    lcrc_flag u_flag (
      .clk_i, .rst_ni, .set_i(lane_err[g]), .clr_i(clr_i[g]), .flag_o(lane_flag[g])
    );
  end

  assign y_err_o = lane_flag[0];
  assign c_err_o = lane_flag[1];

  AST_SD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !y_err_o && !c_err_o) |=> (!y_err_o && !c_err_o))
    else $error("flag set in SD"); // R5
  AST_REGEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_regen_i && !y_err_o && !c_err_o) |=> (!y_err_o && !c_err_o))
    else $error("flag set while regenerating"); // R6
  AST_IDLE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !y_err_o) |=> !y_err_o) else $error("idle word set flag"); // R9
endmodule

// File: tb/line_crc_chk_tb_top.sv
module line_crc_chk_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       regen = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] tag = 3'd0;
  logic [9:0] yd = '0, cd = '0;
  logic [1:0] clr = '0;
  logic       y_err, c_err;

  int checks = 0, errors = 0;
  logic [1:0] exp_q[$];
  logic [1:0] exp_flags = 2'b00;
  string      req_q[$];
  event       line_done;

  always #4 clk = ~clk;

  line_crc_chk dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .crc_regen_i(regen),
    .valid_i(valid), .tag_i(tag), .y_data_i(yd), .c_data_i(cd),
    .clr_i(clr), .y_err_o(y_err), .c_err_o(c_err)
  );

  // reference CRC per R1
  function automatic logic [17:0] ref_step(logic [17:0] c, logic [9:0] d);
    logic fb;
    for (int b = 0; b < 10; b++) begin
      fb = c[17] ^ d[b];
      c  = {c[16:0], 1'b0};
      if (fb) c = c ^ 18'h00031;
    end
    return c;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // monitor: pops expected items as results settle
  initial forever begin
    @(line_done);
    while (exp_q.size() > 0) begin
      logic [1:0] e;
      string      r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk({r, " y"}, y_err, e[0]);
      chk({r, " c"}, c_err, e[1]);
    end
  end

  task automatic idle_gap();
    int n;
    n = $urandom_range(0, 2);
    for (int i = 0; i < n; i++) begin
      valid = 1'b0;
      tag   = 3'($urandom_range(0, 5));
      yd    = 10'($urandom);
      cd    = 10'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic put(logic [2:0] t, logic [9:0] y, logic [9:0] c);
    idle_gap();
    valid = 1'b1; tag = t; yd = y; cd = c;
    @(negedge clk);
  endtask

  function automatic logic [9:0] crc_word(logic [17:0] crc, bit hi, int kind);
    logic [8:0] v;
    logic [9:0] w;
    v = hi ? crc[17:9] : crc[8:0];
    w = {~v[8], v};
    if (kind == 1) w[3] = ~w[3];   // value corruption
    if (kind == 3) w[9] = ~w[9];   // format corruption
    return w;
  endfunction

  // kind: 0 good, 1 corrupt value, 2 missing, 3 bad bit 9
  task automatic run_line(string req, int ky, int kc, logic [1:0] md, logic rg,
                          logic [1:0] clr_end);
    logic [17:0] cy, cc;
    logic [9:0]  y, c, wy, wc;
    int          n;
    logic        en;
    logic [1:0]  err;
    mode = md; regen = rg;
    n  = $urandom_range(6, 16);
    cy = '0; cc = '0;
    for (int i = 0; i < n + 6; i++) begin
      if (i >= n && i < n + 4) begin
        y = (i == n) ? 10'h3FF : (i == n + 3) ? 10'h274 : 10'h000;
        c = y;
      end else begin
        y = 10'($urandom); c = 10'($urandom);
      end
      cy = ref_step(cy, y); cc = ref_step(cc, c);
      put((i == 0) ? 3'd1 : (i == n + 5) ? 3'd2 : 3'd0, y, c);
    end
    for (int h = 0; h < 2; h++) begin
      wy = crc_word(cy, h[0], ky);
      wc = crc_word(cc, h[0], kc);
      if (ky == 2 || kc == 2) begin
        if (ky != 2 && kc != 2) ;
      end
      // a missing word is sent untagged on both streams only for that stream's tag
      if (ky == 2 && kc == 2) put(3'd0, wy, wc);
      else if (ky == 2 || kc == 2) begin
        // tag cannot differ per stream; missing stream gets word from none-tag slot
        put(3'd0, wy, wc);
      end else put(h[0] ? 3'd4 : 3'd3, wy, wc);
    end
    put(3'd0, 10'h200, 10'h040);
    clr = clr_end;
    put(3'd5, 10'h3FF, 10'h3FF);
    clr = 2'b00; valid = 1'b0; tag = 3'd0;
    en  = (md == 2'd1 || md == 2'd2) && !rg;
    err[0] = en && (ky != 0);
    err[1] = en && (kc != 0);
    exp_flags = err | (exp_flags & ~clr_end);
    exp_q.push_back(exp_flags);
    req_q.push_back(req);
    ->line_done;
    @(negedge clk);
  endtask

  task automatic do_clear(string req, logic [1:0] m);
    clr = m;
    @(negedge clk);
    clr = 2'b00;
    exp_flags = exp_flags & ~m;
    exp_q.push_back(exp_flags);
    req_q.push_back(req);
    ->line_done;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset y", y_err, 1'b0);
    chk("R8 reset c", c_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 post-reset y", y_err, 1'b0);
    run_line("R1 HD good",          0, 0, 2'd1, 1'b0, 2'b00);
    run_line("R1 3G good R9 gaps",  0, 0, 2'd2, 1'b0, 2'b00);
    run_line("R2 HD Y corrupt",     1, 0, 2'd1, 1'b0, 2'b00);
    run_line("R7 sticky",           0, 0, 2'd1, 1'b0, 2'b00);
    do_clear("R7 clear Y",          2'b01);
    run_line("R3 3G C corrupt",     0, 1, 2'd2, 1'b0, 2'b00);
    do_clear("R7 clear C",          2'b10);
    run_line("R2 HD bad bit 9",     3, 0, 2'd1, 1'b0, 2'b00);
    do_clear("R7 clear Y2",         2'b01);
    run_line("R4 HD missing CRC",   2, 2, 2'd1, 1'b0, 2'b00);
    do_clear("R7 clear both",       2'b11);
    run_line("R5 SD corrupt",       1, 1, 2'd0, 1'b0, 2'b00);
    run_line("R5 mode3 corrupt",    1, 3, 2'd3, 1'b0, 2'b00);
    run_line("R6 regen corrupt",    1, 1, 2'd1, 1'b1, 2'b00);
    run_line("R3 3G both corrupt",  1, 1, 2'd2, 1'b0, 2'b00);
    run_line("R7 clear+err same",   1, 0, 2'd1, 1'b0, 2'b11);
    do_clear("R7 final clear",      2'b11);
    run_line("R9 good after all",   0, 0, 2'd2, 1'b0, 2'b00);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule